// File: doc/BRIEF.md
# Status LED Blinker with GPIO Pin Override

This block turns one general-purpose pin into a status indicator. Software writes a single 8-bit configuration word. The word holds an enable flag, a 3-bit waveform code, a port select bit and a pin index. While the flag is set and the chosen pin exists, the block raises the override-enable bit for that pin and supplies its drive value. The surrounding GPIO logic must give this override priority over its own direction and data settings.

The waveform can be a steady low, a released level, or a 50 percent square wave at 1 Hz, 1/2 Hz or 1/4 Hz. The released level is high-impedance on an open-drain pad and driven high on a push-pull pad. An internal prescaler derives the blink timebase from the system clock, whose frequency is a parameter. A single free-running divider feeds all three rates, so they share one phase origin that reset clears.

Configuration word layout: bit 7 is the enable, bits 6:4 the waveform code, bit 3 the port (0 = first port, 1 = second port) and bits 2:0 the pin index.

Top module: `led_beacon`

## Requirements
- R1: A synchronous reset clears the configuration word to 0x00, ignores any write presented while reset is high, and leaves ovr_en all zero, drv_val 0 and drv_hiz 0.
- R2: With bit 7 clear, ovr_en stays zero. With bit 7 set and a valid pin, exactly one bit of ovr_en is high, at position port*8 + pin index.
- R3: Waveform code 000 drives the selected pin low, and so do codes 001, 010 and 011: drv_val 0, drv_hiz 0.
- R4: Waveform code 111 releases the selected pin: drv_hiz 1 and drv_val 1.
- R5: Whenever ovr_en is all zero, drv_val and drv_hiz are both 0.
- R6: Code 110 toggles drv_val every CLK_HZ/2 cycles, code 101 every CLK_HZ cycles and code 100 every 2*CLK_HZ cycles (1, 1/2 and 1/4 Hz, 50 percent duty).
- R7: Valid pins are indices 0 to 6 on port 0 and indices 3 to 5 on port 1. Any other index selects no pin, and ovr_en stays zero.
- R8: All blink rates come from one divider that reset clears. Counting clock edges after reset release, the first rising edge of drv_val is visible after edge CLK_HZ/2+1 for code 110, after edge CLK_HZ+1 for code 101 and after edge 2*CLK_HZ+1 for code 100.
- R9: A configuration write is captured on the first clock edge and reaches ovr_en, drv_val and drv_hiz on the second. ovr_en never changes without a write two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration word: enable, waveform code, port, pin index |
| ovr_en | output | NUM_PORTS*PINS_PER_PORT | Per-pin override enable, bit port*PINS_PER_PORT+pin |
| drv_val | output | 1 | Drive value for the overridden pin |
| drv_hiz | output | 1 | High when the overridden pin is to be released |

## Verification
A corrupted configuration register appears at ovr_en two edges after the write that should have set it: a wrong or extra bit, or a missing bit. Errors in the prescaler or the phase divider appear only in the timing of drv_val. A first rise that comes too early or too late, or a half-period of the wrong length, shows within at most two blink periods of reset release. Comparing the first-rise edge count across the three rates exposes a divider that is not shared or not cleared by reset. A bad waveform decode shows on drv_val and drv_hiz in the same cycle as ovr_en.

// File: rtl/led_beacon_pkg.sv
package led_beacon_pkg;

  // width of the shared phase divider: one bit per blink rate
  localparam int PHASE_BITS = 3;

  typedef logic [2:0] wave_code_t;

  localparam wave_code_t WAVE_LOW     = 3'b000;
  localparam wave_code_t WAVE_QUARTER = 3'b100;
  localparam wave_code_t WAVE_HALF    = 3'b101;
  localparam wave_code_t WAVE_ONE     = 3'b110;
  localparam wave_code_t WAVE_RELEASE = 3'b111;

  typedef struct packed {
    logic       en;
    wave_code_t code;
    logic       port;
    logic [2:0] pin;
  } beacon_cfg_t;

endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int HALF = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (cnt == CW'(HALF - 1))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(HALF - 1));
endmodule

// File: rtl/led_phase_div.sv
module led_phase_div #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [WIDTH-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (tick)
      phase <= phase + 1'b1;
  end
endmodule

// File: rtl/led_wave_sel.sv
module led_wave_sel
  import led_beacon_pkg::*;
(
  input  wave_code_t            code,
  input  logic [PHASE_BITS-1:0] phase,
  output logic                  val,
  output logic                  hiz
);
  always_comb begin
    val = 1'b0;
    hiz = 1'b0;
    case (code)
      WAVE_RELEASE: begin
        val = 1'b1;
        hiz = 1'b1;
      end
      WAVE_ONE:     val = phase[0];
      WAVE_HALF:    val = phase[1];
      WAVE_QUARTER: val = phase[2];
      default:      val = 1'b0;
    endcase
  end
endmodule

// File: rtl/led_pin_route.sv
module led_pin_route #(
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_PORTS     = 2,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] VALID_MASK = 'h387F
) (
  input  logic                               en,
  input  logic                               port,
  input  logic [2:0]                         pin,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] sel
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
      if (VALID_MASK[p*PINS_PER_PORT+i]) begin : g_valid
        assign sel[p*PINS_PER_PORT+i] = en && (port == 1'(p)) && (pin == 3'(i));
      end else begin : g_absent
        assign sel[p*PINS_PER_PORT+i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/led_beacon.sv
module led_beacon
  import led_beacon_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_PORTS     = 2,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] VALID_MASK = 'h387F
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [7:0]                         cfg_wdata,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] ovr_en,
  output logic                               drv_val,
  output logic                               drv_hiz
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  beacon_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (cfg_we)
      cfg_q <= beacon_cfg_t'(cfg_wdata);
  end

  logic                  tick;
  logic [PHASE_BITS-1:0] phase;

  led_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  led_phase_div #(.WIDTH(PHASE_BITS)) u_div (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .phase (phase)
  );

  logic [NUM_PINS-1:0] sel;

  led_pin_route #(
    .PINS_PER_PORT (PINS_PER_PORT),
    .NUM_PORTS     (NUM_PORTS),
    .VALID_MASK    (VALID_MASK)
  ) u_route (
    .en   (cfg_q.en),
    .port (cfg_q.port),
    .pin  (cfg_q.pin),
    .sel  (sel)
  );

  logic w_val, w_hiz;

  led_wave_sel u_wave (
    .code  (cfg_q.code),
    .phase (phase),
    .val   (w_val),
    .hiz   (w_hiz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_en  <= '0;
      drv_val <= 1'b0;
      drv_hiz <= 1'b0;
    end else begin
      ovr_en  <= sel;
      drv_val <= (|sel) & w_val;
      drv_hiz <= (|sel) & w_hiz;
    end
  end
endmodule

// File: rtl/led_beacon_chk.sv
module led_beacon_chk #(
  parameter int N = 16,
  parameter logic [N-1:0] VALID_MASK = 'h387F
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_we,
  input logic [N-1:0] ovr_en,
  input logic         drv_val,
  input logic         drv_hiz
);
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ovr_en));

  assert_release_high_R4: assert property (@(posedge clk) disable iff (rst)
    drv_hiz |-> (drv_val && (ovr_en != '0)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (ovr_en == '0) |-> (!drv_val && !drv_hiz));

  assert_valid_pin_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_en & ~VALID_MASK) == '0);

  // reset is held for several cycles, so the window below never spans its edge
  assert_sel_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovr_en) |-> $past(cfg_we, 2));
endmodule

bind led_beacon led_beacon_chk #(
  .N          (NUM_PORTS * PINS_PER_PORT),
  .VALID_MASK (VALID_MASK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_we  (cfg_we),
  .ovr_en  (ovr_en),
  .drv_val (drv_val),
  .drv_hiz (drv_hiz)
);

// File: tb/sim_led_beacon.sv
module sim_led_beacon;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8;
  localparam int HALF       = CLK_HZ / 2;
  localparam int NV         = 13;

  // {cfg[7:0], ovr_en[15:0], drv_val, drv_hiz}
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 16'h0000, 1'b0, 1'b0},  // R2 disabled
    {8'h80, 16'h0001, 1'b0, 1'b0},  // R3 low, port0 pin0
    {8'hF6, 16'h0040, 1'b1, 1'b1},  // R4 release, port0 pin6
    {8'hF7, 16'h0000, 1'b0, 1'b0},  // R7 port0 pin7 invalid
    {8'hFB, 16'h0800, 1'b1, 1'b1},  // R7 port1 pin3
    {8'hFD, 16'h2000, 1'b1, 1'b1},  // R7 port1 pin5
    {8'hFA, 16'h0000, 1'b0, 1'b0},  // R7 port1 pin2 invalid
    {8'hFE, 16'h0000, 1'b0, 1'b0},  // R7 port1 pin6 invalid
    {8'h93, 16'h0008, 1'b0, 1'b0},  // R3 code 001
    {8'hB4, 16'h0010, 1'b0, 1'b0},  // R3 code 011
    {8'h76, 16'h0000, 1'b0, 1'b0},  // R5 enable clear, code 111
    {8'hA9, 16'h0000, 1'b0, 1'b0},  // R5 code 010 on invalid pin
    {8'h8C, 16'h1000, 1'b0, 1'b0}   // R2 port1 pin4
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [15:0] ovr_en;
  logic        drv_val, drv_hiz;
  int          n_chk = 0;
  int          n_fail = 0;
  int          since_rel = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) since_rel <= 0;
    else     since_rel <= since_rel + 1;
  end

  led_beacon #(.CLK_HZ(CLK_HZ)) u0 (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .ovr_en    (ovr_en),
    .drv_val   (drv_val),
    .drv_hiz   (drv_hiz)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // reset, write a blink code together with reset release, check first rise and half-periods
  task automatic blink(logic [2:0] code, int first, int per, string tag);
    int t0;
    int k;
    hold_reset();
    rst = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = {1'b1, code, 1'b0, 3'd2};
    @(negedge clk);
    cfg_we = 1'b0;
    k = 0;
    while (!drv_val && k < 400) begin @(negedge clk); k++; end
    chk({tag, " first rise edge"}, since_rel, first);
    t0 = since_rel;
    k = 0;
    while (drv_val && k < 400) begin @(negedge clk); k++; end
    chk({tag, " high half-period"}, since_rel - t0, per);
    t0 = since_rel;
    k = 0;
    while (!drv_val && k < 400) begin @(negedge clk); k++; end
    chk({tag, " low half-period"}, since_rel - t0, per);
    chk({tag, " pin"}, int'(ovr_en), 32'h0004);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, and a write held during reset is dropped
    rst = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 8'hF6;
    repeat (2) @(negedge clk);
    cfg_we = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ovr_en after reset", int'(ovr_en), 0);
    chk("R1 drv_val after reset", int'(drv_val), 0);
    chk("R1 drv_hiz after reset", int'(drv_hiz), 0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][25:18]);
      @(negedge clk);
      chk($sformatf("table %0d ovr_en", i), int'(ovr_en), int'(VEC[i][17:2]));
      chk($sformatf("table %0d drv_val", i), int'(drv_val), int'(VEC[i][1]));
      chk($sformatf("table %0d drv_hiz", i), int'(drv_hiz), int'(VEC[i][0]));
    end

    // R9: two-edge latency from write strobe to outputs
    write_cfg(8'h00);
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 8'hF5;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 after first edge ovr_en", int'(ovr_en), 0);
    @(negedge clk);
    chk("R9 after second edge ovr_en", int'(ovr_en), 32'h0020);
    chk("R9 after second edge drv_hiz", int'(drv_hiz), 1);

    // R6 and R8: rates and common phase origin
    blink(3'b110, HALF + 1, HALF, "R6 R8 one-hertz");
    blink(3'b101, 2 * HALF + 1, 2 * HALF, "R6 R8 half-hertz");
    blink(3'b100, 4 * HALF + 1, 4 * HALF, "R6 R8 quarter-hertz");

    // R1: mid-run reset clears an active override
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clears override", int'(ovr_en), 0);
    chk("R1 reset clears drive", int'(drv_val), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule